// File: doc/BRIEF.md
# Indirect-Access Branch Trace Record Store

This block holds a ring of control-transfer records. Each record has three words: a source address, a target address and a metadata word. The pipeline writes a new record through a one-cycle record strobe. Each new record lands in the next physical slot and becomes logical entry 0. Older records move one logical position down on every strobe. Once the ring is full, the oldest record is overwritten.

Software does not see the slots directly. It writes a 12-bit window select value and then reads or writes one of six alias registers. Selects 0x200 to 0x2FF each name one logical entry. Aliases 1 to 3 reach that entry's three words, and aliases 4 to 6 are inert. Two select registers exist, one for the normal path and one for the virtualized path. The `csr_virt` input picks which one is used. Both reach the same single copy of the entries.

Every write, from software or from the record port, goes through two filters. The first is a legal-value mask: unimplemented metadata fields and an absent mispredict flag are stored and read as zero. The second applies zero-extension to the narrow register width whenever `xlen_narrow` is high.

Top module: `branch_trace_store`

## Requirements
- R1: Selects 0x200..0x2FF give access to logical entry (select − 0x200). With any other select value, aliases 1..6 read 0 and writes to them change no entry.
- R2: With a select in the window, alias 1 (`csr_reg`=1) reaches the source word, alias 2 the target word, and alias 3 the metadata word of the selected logical entry.
- R3: With a select in the window, aliases 4, 5 and 6 read 0, and writes to them change no entry.
- R4: The virtualized select (`csr_virt`=1) and its aliases reach the same entries as the normal select. A write made through one path is visible through the other.
- R5: On each `rec_valid` cycle, all three words are stored and source bit 0 (the valid flag) is set to 1. The new record becomes logical entry 0 on the next cycle, and logical entry k then holds the record written k strobes earlier.
- R6: Target bit 0 holds the mispredict flag, taken from `rec_misp`. The target address occupies bits [MXLEN-1:1]. When HAS_MISP=0, bit 0 reads 0.
- R7: While `xlen_narrow`=1, software writes and record writes are zero-extended from bit 31. Alias reads return only bits [31:0], with the upper bits at zero.
- R8: Metadata layout: TYPE in bits [3:0], cycle-count-valid in bit 15, and the 16-bit cycle count in bits [31:16] (exponent in [31:28], mantissa in [27:16]). All other bits read 0 and ignore writes, so writing all ones reads back 0xFFFF800F.
- R9: Logical indices at or beyond DEPTH read 0 on every alias, and writes to them change no entry.
- R10: If a software write and a record write target the same physical slot in one cycle, the slot takes the record.
- R11: After reset, both select registers read 0 and every entry reads 0 on aliases 1 to 3.
- R12: `csr_reg`=0 reads and writes the active select register. Writes keep bits [11:0], and reads return them zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlen_narrow | input | 1 | Current register width is 32 bits |
| rec_valid | input | 1 | Record strobe |
| rec_source | input | MXLEN | Source address of the transfer |
| rec_target | input | MXLEN | Target address of the transfer |
| rec_misp | input | 1 | Transfer was mispredicted |
| rec_type | input | 4 | Transfer type code |
| rec_ccv | input | 1 | Cycle count is valid |
| rec_cc | input | 16 | Compressed cycle count |
| csr_virt | input | 1 | Use the virtualized select path |
| csr_reg | input | 3 | 0 = select register, 1..6 = alias registers |
| csr_we | input | 1 | Software write strobe |
| csr_wdata | input | MXLEN | Software write data |
| csr_rdata | output | MXLEN | Read data of the addressed register |

## Verification
The assertions assume that `csr_reg` never exceeds 6 and that reads are taken while `csr_we` is low. Every bench access uses register numbers 0 to 6 and samples the read data one cycle after the last write. The assertions also assume that the width mode changes only between accesses, and the bench changes `xlen_narrow` only while no write or record strobe is active. The bench drives the record port with distinct, arithmetically derived fields, including source values whose bit 0 is clear. This checks that the valid flag is set by the block itself and is not copied from the input.

// File: rtl/bts_pkg.sv
package bts_pkg;

  localparam int SEL_W     = 12;
  localparam int META_W    = 64;
  localparam int TYPE_LSB  = 0;
  localparam int TYPE_W    = 4;
  localparam int CCV_BIT   = 15;
  localparam int CC_LSB    = 16;
  localparam int CC_W      = 16;
  localparam logic [3:0] WINDOW_HI = 4'h2;

  typedef enum logic [2:0] {
    REG_SELECT = 3'd0,
    REG_ALIAS1 = 3'd1,
    REG_ALIAS2 = 3'd2,
    REG_ALIAS3 = 3'd3,
    REG_ALIAS4 = 3'd4,
    REG_ALIAS5 = 3'd5,
    REG_ALIAS6 = 3'd6
  } csr_reg_e;

  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_SRC  = 2'd1,
    FLD_TGT  = 2'd2,
    FLD_META = 2'd3
  } field_e;

  function automatic logic [META_W-1:0] meta_keep(input bit has_type, input bit has_cc);
    logic [META_W-1:0] m;
    m = '0;
    if (has_type) m[TYPE_LSB +: TYPE_W] = '1;
    if (has_cc) begin
      m[CCV_BIT]          = 1'b1;
      m[CC_LSB +: CC_W]   = '1;
    end
    return m;
  endfunction

  function automatic logic [META_W-1:0] meta_pack(input logic [TYPE_W-1:0] ty,
                                                  input logic ccv,
                                                  input logic [CC_W-1:0] cc);
    logic [META_W-1:0] m;
    m = '0;
    m[TYPE_LSB +: TYPE_W] = ty;
    m[CCV_BIT]            = ccv;
    m[CC_LSB +: CC_W]     = cc;
    return m;
  endfunction

endpackage

// File: rtl/bts_sel_decode.sv
module bts_sel_decode
  import bts_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [2:0]       reg_num,
  output field_e           fld,
  output logic [PTR_W-1:0] lidx,
  output logic             in_window
);

  logic in_depth;

  always_comb begin
    in_window = (sel[SEL_W-1:8] == WINDOW_HI);
    in_depth  = ({1'b0, sel[7:0]} < 9'(DEPTH));
    lidx      = sel[PTR_W-1:0];
    fld       = FLD_NONE;
    if (in_window && in_depth) begin
      case (reg_num)
        REG_ALIAS1: fld = FLD_SRC;
        REG_ALIAS2: fld = FLD_TGT;
        REG_ALIAS3: fld = FLD_META;
        default:    fld = FLD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/bts_slot_map.sv
module bts_slot_map #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0] wptr,
  input  logic [PTR_W-1:0] lidx,
  output logic [PTR_W-1:0] slot
);

  always_comb begin
    slot = wptr - PTR_W'(1) - lidx;
  end

endmodule

// File: rtl/bts_entry_array.sv
module bts_entry_array
  import bts_pkg::*;
#(
  parameter int MXLEN = 64,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_en,
  input  logic [PTR_W-1:0]  rec_slot,
  input  logic [MXLEN-1:0]  rec_src,
  input  logic [MXLEN-1:0]  rec_tgt,
  input  logic [META_W-1:0] rec_meta,
  input  logic              sw_en,
  input  field_e            sw_fld,
  input  logic [PTR_W-1:0]  sw_slot,
  input  logic [MXLEN-1:0]  sw_word,
  input  logic [META_W-1:0] sw_meta,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic [MXLEN-1:0]  rd_src,
  output logic [MXLEN-1:0]  rd_tgt,
  output logic [META_W-1:0] rd_meta
);

  logic [DEPTH-1:0][MXLEN-1:0]  src_all;
  logic [DEPTH-1:0][MXLEN-1:0]  tgt_all;
  logic [DEPTH-1:0][META_W-1:0] meta_all;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [MXLEN-1:0]  src_q,  src_d;
    logic [MXLEN-1:0]  tgt_q,  tgt_d;
    logic [META_W-1:0] meta_q, meta_d;
    logic              sw_hit, rec_hit;

    always_comb begin
      sw_hit  = sw_en  && (sw_slot  == PTR_W'(g));
      rec_hit = rec_en && (rec_slot == PTR_W'(g));
      src_d   = src_q;
      tgt_d   = tgt_q;
      meta_d  = meta_q;
      if (sw_hit) begin
        case (sw_fld)
          FLD_SRC:  src_d  = sw_word;
          FLD_TGT:  tgt_d  = sw_word;
          FLD_META: meta_d = sw_meta;
          default:  ;
        endcase
      end
      if (rec_hit) begin
        src_d  = rec_src;
        tgt_d  = rec_tgt;
        meta_d = rec_meta;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q  <= '0;
        tgt_q  <= '0;
        meta_q <= '0;
      end else if (sw_hit || rec_hit) begin
        src_q  <= src_d;
        tgt_q  <= tgt_d;
        meta_q <= meta_d;
      end
    end

    assign src_all[g]  = src_q;
    assign tgt_all[g]  = tgt_q;
    assign meta_all[g] = meta_q;
  end

  always_comb begin
    rd_src  = src_all[rd_slot];
    rd_tgt  = tgt_all[rd_slot];
    rd_meta = meta_all[rd_slot];
  end

endmodule

// File: rtl/branch_trace_store.sv
module branch_trace_store
  import bts_pkg::*;
#(
  parameter int MXLEN       = 64,
  parameter int XLEN_NARROW = 32,
  parameter int DEPTH       = 16,
  parameter bit HAS_MISP    = 1'b1,
  parameter bit HAS_TYPE    = 1'b1,
  parameter bit HAS_CC      = 1'b1,
  localparam int PTR_W      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlen_narrow,
  input  logic             rec_valid,
  input  logic [MXLEN-1:0] rec_source,
  input  logic [MXLEN-1:0] rec_target,
  input  logic             rec_misp,
  input  logic [3:0]       rec_type,
  input  logic             rec_ccv,
  input  logic [15:0]      rec_cc,
  input  logic             csr_virt,
  input  logic [2:0]       csr_reg,
  input  logic             csr_we,
  input  logic [MXLEN-1:0] csr_wdata,
  output logic [MXLEN-1:0] csr_rdata
);

  localparam logic [MXLEN-1:0]  NARROW_MASK = {{(MXLEN-XLEN_NARROW){1'b0}}, {XLEN_NARROW{1'b1}}};
  localparam logic [MXLEN-1:0]  MISP_CLR    = ~MXLEN'(1);
  localparam logic [META_W-1:0] META_KEEP   = meta_keep(HAS_TYPE, HAS_CC);

  // select registers and write pointer
  logic [SEL_W-1:0] sel_sup_q,  sel_sup_d;
  logic [SEL_W-1:0] sel_virt_q, sel_virt_d;
  logic             sel_sup_en, sel_virt_en;
  logic [PTR_W-1:0] wptr_q, wptr_d;

  // access path
  logic [SEL_W-1:0] sel_act;
  field_e           fld;
  logic [PTR_W-1:0] lidx;
  logic             in_window;
  logic [PTR_W-1:0] acc_slot;
  logic [MXLEN-1:0] width_mask;
  logic [MXLEN-1:0] wdata_ext;
  logic [MXLEN-1:0] sw_word;
  logic [META_W-1:0] sw_meta;
  logic             sw_en;

  // record path
  logic [MXLEN-1:0]  rec_src_w, rec_tgt_w;
  logic [META_W-1:0] rec_meta_w;

  // read path
  logic [MXLEN-1:0]  rd_src, rd_tgt;
  logic [META_W-1:0] rd_meta;
  logic [MXLEN-1:0]  rd_raw;

  assign sel_act = csr_virt ? sel_virt_q : sel_sup_q;

  bts_sel_decode #(.DEPTH(DEPTH)) u_decode (
    .sel       (sel_act),
    .reg_num   (csr_reg),
    .fld       (fld),
    .lidx      (lidx),
    .in_window (in_window)
  );

  bts_slot_map #(.DEPTH(DEPTH)) u_map (
    .wptr (wptr_q),
    .lidx (lidx),
    .slot (acc_slot)
  );

  // next state for select registers and pointer
  always_comb begin
    sel_sup_en  = csr_we && (csr_reg == REG_SELECT) && !csr_virt;
    sel_virt_en = csr_we && (csr_reg == REG_SELECT) &&  csr_virt;
    sel_sup_d   = csr_wdata[SEL_W-1:0];
    sel_virt_d  = csr_wdata[SEL_W-1:0];
    wptr_d      = wptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sup_q <= '0;
    end else if (sel_sup_en) begin
      sel_sup_q <= sel_sup_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_virt_q <= '0;
    end else if (sel_virt_en) begin
      sel_virt_q <= sel_virt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (rec_valid) begin
      wptr_q <= wptr_d;
    end
  end

  // write conditioning: width extension and legal-value masks
  always_comb begin
    width_mask = xlen_narrow ? NARROW_MASK : '1;
    wdata_ext  = csr_wdata & width_mask;
    sw_en      = csr_we && (fld != FLD_NONE) && in_window;
    sw_word    = (fld == FLD_TGT && !HAS_MISP) ? (wdata_ext & MISP_CLR) : wdata_ext;
    sw_meta    = META_W'(wdata_ext) & META_KEEP;
  end

  always_comb begin
    rec_src_w  = (rec_source | MXLEN'(1)) & width_mask;
    rec_tgt_w  = ((rec_target & MISP_CLR) | MXLEN'(rec_misp & HAS_MISP)) & width_mask;
    rec_meta_w = meta_pack(rec_type, rec_ccv, rec_cc) & META_KEEP;
  end

  bts_entry_array #(.MXLEN(MXLEN), .DEPTH(DEPTH)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rec_en   (rec_valid),
    .rec_slot (wptr_q),
    .rec_src  (rec_src_w),
    .rec_tgt  (rec_tgt_w),
    .rec_meta (rec_meta_w),
    .sw_en    (sw_en),
    .sw_fld   (fld),
    .sw_slot  (acc_slot),
    .sw_word  (sw_word),
    .sw_meta  (sw_meta),
    .rd_slot  (acc_slot),
    .rd_src   (rd_src),
    .rd_tgt   (rd_tgt),
    .rd_meta  (rd_meta)
  );

  // read mux
  always_comb begin
    case (fld)
      FLD_SRC:  rd_raw = rd_src;
      FLD_TGT:  rd_raw = rd_tgt;
      FLD_META: rd_raw = MXLEN'(rd_meta);
      default:  rd_raw = '0;
    endcase
    if (csr_reg == REG_SELECT) begin
      csr_rdata = MXLEN'(sel_act);
    end else begin
      csr_rdata = rd_raw & width_mask;
    end
  end

endmodule

// File: rtl/branch_trace_store_chk.sv
module branch_trace_store_chk
  import bts_pkg::*;
#(
  parameter int MXLEN = 64,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xlen_narrow,
  input logic             rec_valid,
  input logic             csr_virt,
  input logic [2:0]       csr_reg,
  input logic             csr_we,
  input logic [MXLEN-1:0] csr_rdata,
  input logic [SEL_W-1:0] sel_sup_q,
  input logic [SEL_W-1:0] sel_virt_q,
  input logic [PTR_W-1:0] wptr_q
);

  localparam logic [META_W-1:0] META_ALL = meta_keep(1'b1, 1'b1);

  logic [SEL_W-1:0] sel_act;
  assign sel_act = csr_virt ? sel_virt_q : sel_sup_q;

  // R1
  outside_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_reg != 3'd0) && (sel_act[SEL_W-1:8] != 4'h2) |-> csr_rdata == '0);

  // R3
  inert_alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_reg >= 3'd4) |-> csr_rdata == '0);

  // R5
  wptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> wptr_q == PTR_W'($past(wptr_q) + 1'b1));

  // R5
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> $stable(wptr_q));

  // R7
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlen_narrow && (csr_reg != 3'd0) |-> csr_rdata[MXLEN-1:32] == '0);

  // R8
  meta_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_reg == 3'd3) |-> (csr_rdata[META_W-1:0] & ~META_ALL) == '0);

  // R12
  select_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_reg == 3'd0) |-> csr_rdata == MXLEN'(sel_act));

  // R12
  select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> $stable(sel_sup_q) && $stable(sel_virt_q));

endmodule

bind branch_trace_store branch_trace_store_chk #(.MXLEN(MXLEN), .PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xlen_narrow (xlen_narrow),
  .rec_valid   (rec_valid),
  .csr_virt    (csr_virt),
  .csr_reg     (csr_reg),
  .csr_we      (csr_we),
  .csr_rdata   (csr_rdata),
  .sel_sup_q   (sel_sup_q),
  .sel_virt_q  (sel_virt_q),
  .wptr_q      (wptr_q)
);

// File: tb/branch_trace_store_bench.sv
module branch_trace_store_bench;

  localparam int DEPTH = 8;
  localparam logic [63:0] LOW32 = 64'h0000_0000_FFFF_FFFF;

  logic        clk;
  logic        rst_n;
  logic        xlen_narrow;
  logic        rec_valid;
  logic [63:0] rec_source;
  logic [63:0] rec_target;
  logic        rec_misp;
  logic [3:0]  rec_type;
  logic        rec_ccv;
  logic [15:0] rec_cc;
  logic        csr_virt;
  logic [2:0]  csr_reg;
  logic        csr_we;
  logic [63:0] csr_wdata;
  logic [63:0] csr_rdata;

  int checks;
  int fails;
  int recs;

  branch_trace_store #(.MXLEN(64), .XLEN_NARROW(32), .DEPTH(DEPTH)) u_branch_trace_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .xlen_narrow (xlen_narrow),
    .rec_valid   (rec_valid),
    .rec_source  (rec_source),
    .rec_target  (rec_target),
    .rec_misp    (rec_misp),
    .rec_type    (rec_type),
    .rec_ccv     (rec_ccv),
    .rec_cc      (rec_cc),
    .csr_virt    (csr_virt),
    .csr_reg     (csr_reg),
    .csr_we      (csr_we),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] src_of(int n);
    return 64'hC000_0000_0000_0000 | (64'(n) << 8) | 64'(n & 1);
  endfunction
  function automatic logic [63:0] tgt_of(int n);
    return 64'h0000_7FFF_0000_0001 + (64'(n) << 12);
  endfunction
  function automatic logic [63:0] exp_src(int n);
    return src_of(n) | 64'd1;
  endfunction
  function automatic logic [63:0] exp_tgt(int n);
    return (tgt_of(n) & ~64'd1) | 64'((n >> 1) & 1);
  endfunction
  function automatic logic [63:0] exp_meta(int n);
    logic [15:0] cc;
    cc = 16'(n * 16'h0123);
    return {32'd0, cc, 1'(n & 1), 11'd0, 4'(n)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic v, input logic [2:0] r, input logic [63:0] d);
    @(negedge clk);
    csr_virt  = v;
    csr_reg   = r;
    csr_wdata = d;
    csr_we    = 1'b1;
    @(negedge clk);
    csr_we    = 1'b0;
  endtask

  task automatic csr_read(input logic v, input logic [2:0] r, output logic [63:0] q);
    @(negedge clk);
    csr_virt = v;
    csr_reg  = r;
    #2;
    q = csr_rdata;
  endtask

  task automatic drive_rec(input int n);
    rec_source = src_of(n);
    rec_target = tgt_of(n);
    rec_misp   = 1'((n >> 1) & 1);
    rec_type   = 4'(n);
    rec_ccv    = 1'(n & 1);
    rec_cc     = 16'(n * 16'h0123);
  endtask

  task automatic record(input int n);
    @(negedge clk);
    drive_rec(n);
    rec_valid = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0;
    recs++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] q;
    checks = 0; fails = 0; recs = 0;
    rst_n = 1'b0; xlen_narrow = 1'b0; rec_valid = 1'b0;
    rec_source = '0; rec_target = '0; rec_misp = 1'b0;
    rec_type = '0; rec_ccv = 1'b0; rec_cc = '0;
    csr_virt = 1'b0; csr_reg = 3'd0; csr_we = 1'b0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    csr_read(1'b0, 3'd0, q); check("R11 sup select", q, 64'd0);
    csr_read(1'b1, 3'd0, q); check("R11 virt select", q, 64'd0);
    for (int i = 0; i < DEPTH; i++) begin
      csr_write(1'b0, 3'd0, 64'h200 + 64'(i));
      for (int r = 1; r <= 3; r++) begin
        csr_read(1'b0, 3'(r), q); check("R11 entry empty", q, 64'd0);
      end
    end

    // R5 R2 R6 R8 R9: fill past wrap, sweep every logical index
    for (int n = 0; n < 11; n++) record(n);
    for (int i = 0; i < DEPTH + 3; i++) begin
      csr_write(1'b0, 3'd0, 64'h200 + 64'(i));
      if (i < DEPTH) begin
        csr_read(1'b0, 3'd1, q); check("R5 R2 source", q, exp_src(10 - i));
        csr_read(1'b0, 3'd2, q); check("R6 R2 target", q, exp_tgt(10 - i));
        csr_read(1'b0, 3'd3, q); check("R8 R2 metadata", q, exp_meta(10 - i));
      end else begin
        for (int r = 1; r <= 3; r++) begin
          csr_read(1'b0, 3'(r), q); check("R9 beyond depth", q, 64'd0);
        end
      end
    end

    // R9 write beyond depth has no effect
    csr_write(1'b0, 3'd0, 64'h208);
    csr_write(1'b0, 3'd1, 64'hDEAD_BEEF_DEAD_BEEF);
    csr_read(1'b0, 3'd1, q); check("R9 write ignored", q, 64'd0);
    csr_write(1'b0, 3'd0, 64'h207);
    csr_read(1'b0, 3'd1, q); check("R9 oldest intact", q, exp_src(3));

    // R3 inert aliases
    csr_write(1'b0, 3'd0, 64'h200);
    for (int r = 4; r <= 6; r++) begin
      csr_write(1'b0, 3'(r), 64'hFFFF_FFFF_FFFF_FFFF);
      csr_read(1'b0, 3'(r), q); check("R3 inert read", q, 64'd0);
    end
    csr_read(1'b0, 3'd1, q); check("R3 source intact", q, exp_src(10));
    csr_read(1'b0, 3'd2, q); check("R3 target intact", q, exp_tgt(10));
    csr_read(1'b0, 3'd3, q); check("R3 metadata intact", q, exp_meta(10));

    // R1 outside window
    csr_write(1'b0, 3'd0, 64'h1FF);
    for (int r = 1; r <= 3; r++) begin
      csr_read(1'b0, 3'(r), q); check("R1 below window", q, 64'd0);
    end
    csr_write(1'b0, 3'd0, 64'h300);
    csr_write(1'b0, 3'd1, 64'h1111_2222_3333_4444);
    csr_read(1'b0, 3'd1, q); check("R1 above window", q, 64'd0);
    csr_write(1'b0, 3'd0, 64'h200);
    csr_read(1'b0, 3'd1, q); check("R1 write ignored", q, exp_src(10));

    // R12 select readback
    csr_write(1'b0, 3'd0, 64'hFFFF_FABC);
    csr_read(1'b0, 3'd0, q); check("R12 select low bits", q, 64'hABC);

    // R4 shared storage through the virtualized path
    csr_write(1'b1, 3'd0, 64'h202);
    csr_read(1'b1, 3'd2, q); check("R4 virt target", q, exp_tgt(8));
    csr_write(1'b1, 3'd1, 64'h1357_9BDF_0246_8ACE);
    csr_write(1'b0, 3'd0, 64'h202);
    csr_read(1'b0, 3'd1, q); check("R4 sup sees virt write", q, 64'h1357_9BDF_0246_8ACE);
    csr_read(1'b0, 3'd0, q); check("R12 sup select", q, 64'h202);

    // R8 metadata masking
    csr_write(1'b0, 3'd0, 64'h203);
    csr_write(1'b0, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_read(1'b0, 3'd3, q); check("R8 legal bits only", q, 64'hFFFF_800F);

    // R7 narrow width
    csr_write(1'b0, 3'd0, 64'h200);
    xlen_narrow = 1'b1;
    csr_read(1'b0, 3'd1, q); check("R7 narrow read", q, exp_src(10) & LOW32);
    csr_write(1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    xlen_narrow = 1'b0;
    csr_read(1'b0, 3'd1, q); check("R7 narrow write", q, 64'h0000_0000_FFFF_FFFF);
    xlen_narrow = 1'b1;
    record(40);
    xlen_narrow = 1'b0;
    csr_read(1'b0, 3'd1, q); check("R7 narrow record source", q, exp_src(40) & LOW32);
    csr_read(1'b0, 3'd2, q); check("R7 narrow record target", q, exp_tgt(40) & LOW32);
    csr_write(1'b0, 3'd0, 64'h201);
    csr_read(1'b0, 3'd1, q); check("R5 shifted down", q, 64'h0000_0000_FFFF_FFFF);

    // R10 collision: logical DEPTH-1 maps to the slot being recorded
    csr_write(1'b0, 3'd0, 64'h200 + 64'(DEPTH - 1));
    @(negedge clk);
    csr_virt  = 1'b0;
    csr_reg   = 3'd1;
    csr_wdata = 64'h5555_5555_5555_5554;
    csr_we    = 1'b1;
    drive_rec(50);
    rec_valid = 1'b1;
    @(negedge clk);
    csr_we    = 1'b0;
    rec_valid = 1'b0;
    csr_write(1'b0, 3'd0, 64'h200);
    csr_read(1'b0, 3'd1, q); check("R10 record wins source", q, exp_src(50));
    csr_read(1'b0, 3'd3, q); check("R10 record wins metadata", q, exp_meta(50));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule